// File: doc/BRIEF.md
# Exception Vectoring and Privilege Controller

This block is the exception control path of a simple in-order CPU. It keeps three pieces of privileged state: the base address of an exception table held in memory, a saved-PC register, and a one-bit kernel-mode flag, with an interrupt-enable bit beside them. When one or more exception causes are raised, it selects one cause and records the PC of the interrupted instruction. It then switches to kernel mode and reads the 8-byte handler pointer for that cause from the table through a request/acknowledge read port. Fetch stays stalled until the pointer arrives, and then fetch is redirected to it.

The commit stage also presents privileged instructions: load the table base, write the saved PC, write the interrupt enable, and return from exception. In kernel mode they take effect. In user mode none of them executes, and a privilege-violation exception is raised in their place. Because of this, user code cannot retarget the table. Kernel code can overwrite the saved PC, so a return can resume a different process.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After reset the block is in kernel mode, the table base and the saved PC are zero, interrupts are disabled, and `mem_req`, `fetch_stall` and `redirect_valid` are low.
- R2: In the cycle after an exception is accepted, `saved_pc` holds the value that `cur_pc` had in the cycle of acceptance.
- R3: In the cycle after an exception is accepted, `kernel_mode` is 1, whatever mode the block was in before.
- R4: After acceptance, `mem_req` and `fetch_stall` are high and `mem_addr` = table base + 8 × cause. Both stay steady until the cycle in which `mem_ack` is high. In the following cycle `redirect_valid` is high for one cycle with `redirect_pc` = `mem_rdata`, and `fetch_stall` is low.
- R5: The cause codes are 0 divide by zero, 1 invalid instruction, 2 privilege violation, 3 address outside the address space, 4 system call, 5 abort (codes 0 to 5 are synchronous), 6 timer, and 7 I/O (asynchronous). When several causes are raised together, a synchronous cause always wins over an asynchronous one. Within the same class, the lowest code wins.
- R6: A synchronous cause is always accepted. An asynchronous cause is accepted only in user mode or when the interrupt enable is set. In kernel mode with the enable clear, it is ignored: no read is issued and no state changes.
- R7: A return (`op_code` 3) in kernel mode drives `redirect_valid` high in the next cycle with `redirect_pc` equal to the saved PC, and clears `kernel_mode`.
- R8: A base load (`op_code` 0) in kernel mode sets the table base to `op_operand`. In user mode, any privileged op leaves the base unchanged and raises cause 2, saving `cur_pc`.
- R9: In kernel mode, `op_code` 1 writes `op_operand` into the saved PC (a later return goes there), and `op_code` 2 writes `op_operand[0]` into the interrupt enable.
- R10: If an exception is accepted in the same cycle as a kernel-mode op, the op has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_req | input | NCAUSE | Raised exception causes, one bit per cause code |
| cur_pc | input | XLEN | PC of the instruction at the commit point |
| op_valid | input | 1 | A privileged op is presented |
| op_code | input | 2 | 0 base load, 1 saved-PC write, 2 enable write, 3 return |
| op_operand | input | XLEN | Operand of the op |
| mem_req | output | 1 | Handler-pointer read request |
| mem_addr | output | XLEN | Byte address of the table entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Handler pointer read from the table |
| fetch_stall | output | 1 | Hold instruction fetch |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | XLEN | Redirect target |
| kernel_mode | output | 1 | Current privilege flag |
| irq_enable | output | 1 | Kernel-mode interrupt enable |
| tbl_base | output | XLEN | Current table base |
| saved_pc | output | XLEN | Saved-PC register |

## Verification
Single causes are raised one at a time from user mode and from kernel mode. Each must produce its own table offset, which shows that the cause code reaches the address correctly. Mixed request vectors (synchronous plus asynchronous, and two asynchronous) tell the class ordering apart from the lowest-code ordering. Privileged ops issued from user mode are distinguished from the same ops issued in kernel mode, and from ops that coincide with a fault, by reading the table base and saved PC back at the ports. Different acknowledge delays show that the request and stall are held steady for as long as memory takes.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    typedef enum logic [1:0] {
        OP_SET_BASE = 2'd0,
        OP_WR_EPC   = 2'd1,
        OP_WR_IE    = 2'd2,
        OP_RETURN   = 2'd3
    } priv_op_e;

    typedef enum logic {
        VS_RUN   = 1'b0,
        VS_FETCH = 1'b1
    } vec_state_e;

    localparam int unsigned CAUSE_PRIV_VIOL = 2;

endpackage

// File: rtl/exc_cause_pick.sv
module exc_cause_pick #(
    parameter int unsigned               NCAUSE    = 8,
    parameter logic [NCAUSE-1:0]         SYNC_MASK = 8'h3F,
    localparam int unsigned              CW        = $clog2(NCAUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] req,
    output logic              hit,
    output logic [CW-1:0]     idx
);

    logic [NCAUSE-1:0] sync_req;
    logic [NCAUSE-1:0] async_req;

    // split each lane into its class
    for (genvar g = 0; g < NCAUSE; g++) begin : g_lane
        assign sync_req[g]  = req[g] &  SYNC_MASK[g];
        assign async_req[g] = req[g] & ~SYNC_MASK[g];
    end

    always_comb begin
        hit = |req;
        idx = '0;
        // later assignments win: async first, then sync overrides
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (async_req[i]) idx = CW'(i);
        end
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (sync_req[i]) idx = CW'(i);
        end
    end

    AST_SYNC_BEFORE_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (|sync_req)) |-> SYNC_MASK[idx]) else $error("async picked over sync"); // R5

    AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req[idx]) else $error("picked an idle cause"); // R5

endmodule

// File: rtl/exc_priv_regs.sv
module exc_priv_regs
    import exc_vec_pkg::*;
#(
    parameter int unsigned     XLEN       = 64,
    parameter logic [XLEN-1:0] RESET_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] take_pc,
    input  logic            op_go,
    input  priv_op_e        op_kind,
    input  logic [XLEN-1:0] op_data,
    output logic            kernel_mode,
    output logic            irq_en,
    output logic [XLEN-1:0] tbl_base,
    output logic [XLEN-1:0] epc
);

    typedef struct packed {
        logic            kernel;
        logic            ie;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] epc;
    } priv_regs_t;

    priv_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (take) begin
            regs_d.epc    = take_pc;
            regs_d.kernel = 1'b1;
        end else if (op_go) begin
            unique case (op_kind)
                OP_SET_BASE: regs_d.base   = op_data;
                OP_WR_EPC:   regs_d.epc    = op_data;
                OP_WR_IE:    regs_d.ie     = op_data[0];
                OP_RETURN:   regs_d.kernel = 1'b0;
                default:     regs_d        = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.kernel <= 1'b1;
            regs_q.ie     <= 1'b0;
            regs_q.base   <= RESET_BASE;
            regs_q.epc    <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign kernel_mode = regs_q.kernel;
    assign irq_en      = regs_q.ie;
    assign tbl_base    = regs_q.base;
    assign epc         = regs_q.epc;

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (regs_q.epc == $past(take_pc))) else $error("pc not saved"); // R2

    AST_KERNEL_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> regs_q.kernel) else $error("kernel bit not set"); // R3

    AST_BASE_USER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.kernel |=> $stable(regs_q.base)) else $error("base moved in user mode"); // R8

endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
    import exc_vec_pkg::*;
#(
    parameter int unsigned  XLEN   = 64,
    parameter int unsigned  NCAUSE = 8,
    localparam int unsigned CW     = $clog2(NCAUSE),
    localparam int unsigned PSHIFT = $clog2(XLEN / 8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [CW-1:0]   take_cause,
    input  logic [XLEN-1:0] tbl_base,
    input  logic            ret_go,
    input  logic [XLEN-1:0] ret_pc,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_ack,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    typedef struct packed {
        vec_state_e      st;
        logic [CW-1:0]   cause;
        logic            rv;
        logic [XLEN-1:0] rpc;
    } fetch_state_t;

    fetch_state_t fs_d, fs_q;

    always_comb begin
        fs_d    = fs_q;
        fs_d.rv = 1'b0;
        unique case (fs_q.st)
            VS_RUN: begin
                if (take) begin
                    fs_d.st    = VS_FETCH;
                    fs_d.cause = take_cause;
                end else if (ret_go) begin
                    fs_d.rv  = 1'b1;
                    fs_d.rpc = ret_pc;
                end
            end
            VS_FETCH: begin
                if (mem_ack) begin
                    fs_d.st  = VS_RUN;
                    fs_d.rv  = 1'b1;
                    fs_d.rpc = mem_rdata;
                end
            end
            default: fs_d.st = VS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q.st    <= VS_RUN;
            fs_q.cause <= '0;
            fs_q.rv    <= 1'b0;
            fs_q.rpc   <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign busy           = (fs_q.st == VS_FETCH);
    assign mem_req        = busy;
    assign mem_addr       = tbl_base + ({{(XLEN - CW){1'b0}}, fs_q.cause} << PSHIFT);
    assign redirect_valid = fs_q.rv;
    assign redirect_pc    = fs_q.rpc;

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))) else $error("read dropped"); // R4

    AST_REDIRECT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (redirect_valid && !busy && redirect_pc == $past(mem_rdata)))
        else $error("no redirect after ack"); // R4

    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_go && !busy && !take) |=> (redirect_valid && redirect_pc == $past(ret_pc)))
        else $error("bad return target"); // R7

endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_vec_pkg::*;
#(
    parameter int unsigned       XLEN       = 64,
    parameter int unsigned       NCAUSE     = 8,
    parameter logic [NCAUSE-1:0] SYNC_MASK  = 8'h3F,
    parameter logic [XLEN-1:0]   RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] cause_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [XLEN-1:0]   op_operand,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              fetch_stall,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              kernel_mode,
    output logic              irq_enable,
    output logic [XLEN-1:0]   tbl_base,
    output logic [XLEN-1:0]   saved_pc
);

    localparam int unsigned CW = $clog2(NCAUSE);

    logic              busy;
    logic              kern;
    logic              ie;
    logic [XLEN-1:0]   base;
    logic [XLEN-1:0]   epc;
    logic              allow_async;
    logic              priv_fault;
    logic [NCAUSE-1:0] eff_req;
    logic              hit;
    logic [CW-1:0]     pick;
    logic              take;
    logic              op_go;
    logic              ret_go;
    priv_op_e          op_kind;

    always_comb begin
        op_kind     = priv_op_e'(op_code);
        allow_async = !kern || ie;
        priv_fault  = op_valid && !kern;
        eff_req     = (cause_req & (SYNC_MASK | {NCAUSE{allow_async}}))
                    | (NCAUSE'(priv_fault) << CAUSE_PRIV_VIOL);
        take        = hit && !busy;
        op_go       = op_valid && kern && !busy && !take;
        ret_go      = op_go && (op_kind == OP_RETURN);
    end

    exc_cause_pick #(
        .NCAUSE    (NCAUSE),
        .SYNC_MASK (SYNC_MASK)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (eff_req),
        .hit   (hit),
        .idx   (pick)
    );

    exc_priv_regs #(
        .XLEN       (XLEN),
        .RESET_BASE (RESET_BASE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .take_pc     (cur_pc),
        .op_go       (op_go),
        .op_kind     (op_kind),
        .op_data     (op_operand),
        .kernel_mode (kern),
        .irq_en      (ie),
        .tbl_base    (base),
        .epc         (epc)
    );

    exc_vec_fetch #(
        .XLEN   (XLEN),
        .NCAUSE (NCAUSE)
    ) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .take           (take),
        .take_cause     (pick),
        .tbl_base       (base),
        .ret_go         (ret_go),
        .ret_pc         (epc),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .busy           (busy),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    assign fetch_stall = busy;
    assign kernel_mode = kern;
    assign irq_enable  = ie;
    assign tbl_base    = base;
    assign saved_pc    = epc;

    AST_KERNEL_ASYNC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kern && !ie && !op_valid && ((cause_req & SYNC_MASK) == '0)) |=> !mem_req)
        else $error("masked interrupt taken"); // R6

    AST_RETURN_LEAVES_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && kern && op_valid && op_code == 2'd3 && cause_req == '0) |=> !kernel_mode)
        else $error("return kept kernel mode"); // R7

    AST_USER_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !kern && op_valid) |=> (mem_req && kernel_mode))
        else $error("user privileged op not trapped"); // R8

endmodule

// File: tb/exc_vector_ctrl_bench.sv
module exc_vector_ctrl_bench;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      cause_req = '0;
    logic [XLEN-1:0] cur_pc = '0;
    logic            op_valid = 1'b0;
    logic [1:0]      op_code = '0;
    logic [XLEN-1:0] op_operand = '0;
    logic            mem_req;
    logic [XLEN-1:0] mem_addr;
    logic            mem_ack = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            fetch_stall;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic            kernel_mode;
    logic            irq_enable;
    logic [XLEN-1:0] tbl_base;
    logic [XLEN-1:0] saved_pc;

    int total = 0;
    int bad   = 0;
    logic [XLEN-1:0] exp_base = '0;

    always #5 clk = ~clk;

    exc_vector_ctrl u_exc_vector_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cause_req      (cause_req),
        .cur_pc         (cur_pc),
        .op_valid       (op_valid),
        .op_code        (op_code),
        .op_operand     (op_operand),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .fetch_stall    (fetch_stall),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .kernel_mode    (kernel_mode),
        .irq_enable     (irq_enable),
        .tbl_base       (tbl_base),
        .saved_pc       (saved_pc)
    );

    function automatic logic [XLEN-1:0] handler_of(input logic [XLEN-1:0] a);
        return a ^ 64'hA5A5_0000_0000_0F00;
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] code, input logic [XLEN-1:0] val);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_operand = val;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // raise causes and/or an op, then serve the table read after dly cycles
    task automatic take_exc(input logic [7:0] mask, input logic opv, input logic [1:0] code,
                            input logic [XLEN-1:0] val, input logic [XLEN-1:0] pc,
                            input int cause, input int dly, input string tag);
        logic [XLEN-1:0] a;
        a = exp_base + XLEN'(cause) * 8;
        @(negedge clk);
        cause_req = mask; cur_pc = pc;
        op_valid = opv; op_code = code; op_operand = val;
        @(negedge clk);
        cause_req = '0; op_valid = 1'b0;
        chk({tag, " R4 mem_req"}, XLEN'(mem_req), 1);
        chk({tag, " R4/R5 mem_addr"}, mem_addr, a);
        chk({tag, " R4 stall"}, XLEN'(fetch_stall), 1);
        chk({tag, " R3 kernel"}, XLEN'(kernel_mode), 1);
        chk({tag, " R2 saved_pc"}, saved_pc, pc);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk({tag, " R4 held"}, {XLEN'(mem_req & fetch_stall & ~redirect_valid)}, 1);
            chk({tag, " R4 addr held"}, mem_addr, a);
        end
        mem_ack = 1'b1; mem_rdata = handler_of(a);
        @(negedge clk);
        mem_ack = 1'b0;
        chk({tag, " R4 redirect_valid"}, XLEN'(redirect_valid), 1);
        chk({tag, " R4 redirect_pc"}, redirect_pc, handler_of(a));
        chk({tag, " R4 stall released"}, XLEN'(fetch_stall | mem_req), 0);
    endtask

    task automatic back_to_user(input logic [XLEN-1:0] pc);
        do_op(2'd1, pc);
        chk("R9 saved_pc write", saved_pc, pc);
        do_op(2'd3, '0);
        chk("R7 return strobe", XLEN'(redirect_valid), 1);
        chk("R7 return target", redirect_pc, pc);
        chk("R7 user mode", XLEN'(kernel_mode), 0);
    endtask

    task automatic t_reset;
        chk("R1 kernel", XLEN'(kernel_mode), 1);
        chk("R1 base", tbl_base, 0);
        chk("R1 saved_pc", saved_pc, 0);
        chk("R1 ie", XLEN'(irq_enable), 0);
        chk("R1 outputs idle", XLEN'({mem_req, fetch_stall, redirect_valid}), 0);
    endtask

    task automatic t_kernel_setup;
        do_op(2'd0, 64'h8000);
        exp_base = 64'h8000;
        chk("R8 kernel base load", tbl_base, 64'h8000);
        @(negedge clk);
        cause_req = 8'h40;
        @(negedge clk);
        cause_req = '0;
        chk("R6 masked timer ignored", XLEN'({mem_req, fetch_stall}), 0);
        @(negedge clk);
        chk("R6 masked timer no state", saved_pc, 0);
        back_to_user(64'h4000);
    endtask

    task automatic t_user_causes;
        take_exc(8'h10, 1'b0, 2'd0, '0, 64'h4010, 4, 2, "syscall");
        back_to_user(64'h4014);
        take_exc(8'hD2, 1'b0, 2'd0, '0, 64'h4020, 1, 0, "R5 mixed");
        back_to_user(64'h4024);
        take_exc(8'hC0, 1'b0, 2'd0, '0, 64'h4030, 6, 1, "R5/R6 two async user");
        back_to_user(64'h4034);
        take_exc(8'h00, 1'b1, 2'd0, 64'h1234, 64'h4040, 2, 1, "R8 user base load");
        chk("R8 base unchanged", tbl_base, 64'h8000);
    endtask

    task automatic t_kernel_cases;
        do_op(2'd2, 64'h1);
        chk("R9 ie write", XLEN'(irq_enable), 1);
        take_exc(8'h80, 1'b0, 2'd0, '0, 64'h4050, 7, 0, "R6 enabled kernel irq");
        take_exc(8'h01, 1'b1, 2'd0, 64'h9990, 64'h4060, 0, 3, "R10 op with fault");
        chk("R10 op suppressed", tbl_base, 64'h8000);
        do_op(2'd0, 64'hA000);
        exp_base = 64'hA000;
        chk("R8 second base load", tbl_base, 64'hA000);
        take_exc(8'h28, 1'b0, 2'd0, '0, 64'h4070, 3, 4, "R4 new base");
        back_to_user(64'h7777_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_kernel_setup();
        t_user_causes();
        t_kernel_cases();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule